// File: doc/BRIEF.md
# Load-and-release frame serializer

This block is the transmit end of a serial link that marks each byte with a long run of stop bits. A data word is loaded in parallel into a register chain. The chain then holds a complete frame, made of a high preamble, a low start bit and the data bits. The line stays high while the frame waits. A release command switches the block from waiting to streaming. From then on the chain shifts one bit onto the line per pacing tick. The pacing tick is a clock-enable taken from a slower time base.

The block has three states:
- Empty: no frame is held.
- Armed: a frame is held and waits.
- Streaming: the frame is being sent.

When the last data bit has had its full bit period, the held frame counts as consumed and the block goes back to empty. Another release without a new load does nothing. The preamble length and the data width are parameters. Both default to 8.

Top module: `frame_release_tx`

## Requirements
- R1: A load strobe in the empty or armed state captures `tx_word`. If several loads arrive before a release, the frame sent is the one from the last load.
- R2: In the armed state the line is high and `tx_busy` is low. Pacing ticks in this state change neither the held frame nor the line.
- R3: A released frame is sent in this order: PREAMBLE_W high bits (8 by default), then one low start bit, then the DATA_W bits of the word, least significant bit first. Frame bit k is on the line during the k-th bit period, counting from 0.
- R4: A release strobe in the armed state starts streaming. From the next cycle `tx_busy` is high and frame bit 0 is on the line. Every pacing tick while streaming advances the line by exactly one bit. A pacing tick in the cycle of the release does not advance it.
- R5: A release strobe while no frame is held is ignored and `tx_busy` stays low. This covers the state after reset and the state after a frame has been sent.
- R6: A load strobe while streaming is ignored. The frame in progress is unchanged, and no frame is held once it ends.
- R7: On the cycle after the pacing tick that ends the last data bit, `tx_busy` is low, the line is high and the block is empty.
- R8: If load and release strobes arrive in the same cycle:
  - In the armed state, the release wins and the load is dropped.
  - In the empty state, the load wins and the release is dropped.
- R9: The line is high whenever `tx_busy` is low, including right after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_word | input | DATA_W | Data word captured on load |
| load_stb | input | 1 | Load the frame built from `tx_word` |
| go_stb | input | 1 | Release the held frame onto the line |
| pace_en | input | 1 | Bit-pacing clock-enable |
| tx_line | output | 1 | Serial line, high when idle |
| tx_busy | output | 1 | High while a frame is streaming |

## Verification
Two pairs of strobes can fall in the same cycle.

Load and release together:
- The bench drives them in the same cycle, once with a frame held and once with none.
- With a frame held, the bench judges the outcome by which data word streams out.
- With no frame held, it judges whether `tx_busy` rises.
- After the held case, a further release must be ignored, which shows that the coincident load was dropped.

Pacing tick and release together:
- The bench drives a pacing tick in the release cycle on every other frame of a sweep over all 256 data words.
- It checks that frame bit 0 still has its full period.

// File: rtl/frt_pkg.sv
package frt_pkg;

  typedef enum logic [1:0] {
    ST_EMPTY  = 2'd0,
    ST_ARMED  = 2'd1,
    ST_STREAM = 2'd2
  } frt_state_e;

  // number of line bits in one frame: preamble, start bit, data
  function automatic int frame_len(input int pre_w, input int data_w);
    return pre_w + 1 + data_w;
  endfunction

  // width of an index that can address every frame bit
  function automatic int index_width(input int pre_w, input int data_w);
    int n;
    n = frame_len(pre_w, data_w);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/frt_ctrl.sv
module frt_ctrl
  import frt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_stb,
  input  logic       go_stb,
  input  logic       pace_en,
  input  logic       at_last_bit,
  output frt_state_e state,
  output logic       load_take,
  output logic       go_take,
  output logic       bit_tick,
  output logic       frame_done
);

  frt_state_e state_nx;

  // event wires, named so the assertions below can refer to them
  always_comb begin
    load_take  = load_stb && ((state == ST_EMPTY) ||
                              ((state == ST_ARMED) && !go_stb));
    go_take    = go_stb && (state == ST_ARMED);
    bit_tick   = pace_en && (state == ST_STREAM);
    frame_done = bit_tick && at_last_bit;
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_EMPTY:  if (load_take)  state_nx = ST_ARMED;
      ST_ARMED:  if (go_take)    state_nx = ST_STREAM;
      ST_STREAM: if (frame_done) state_nx = ST_EMPTY;
      default:                   state_nx = ST_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_EMPTY;
    else        state <= state_nx;
  end

  AST_EMPTY_NO_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EMPTY) |=> (state != ST_STREAM)); // R5
  AST_STREAM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_STREAM) && !frame_done) |=> (state == ST_STREAM)); // R6
  AST_DONE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (state == ST_EMPTY)); // R7
  AST_GO_BEATS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_ARMED) && go_stb && load_stb) |=> (state == ST_STREAM)); // R8
  AST_ARMED_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_ARMED) && !go_stb) |=> (state == ST_ARMED)); // R2

endmodule

// File: rtl/frt_bitcount.sv
module frt_bitcount #(
  parameter int FRAME_W = 17,
  parameter int IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  output logic [IDX_W-1:0] bit_idx,
  output logic             at_last_bit
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  assign at_last_bit = (bit_idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n)                       bit_idx <= '0;
    else if (restart)                 bit_idx <= '0;
    else if (advance && at_last_bit)  bit_idx <= '0;
    else if (advance)                 bit_idx <= bit_idx + 1'b1;
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx <= LAST_IDX); // R3
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart && !at_last_bit) |=> (bit_idx == $past(bit_idx) + 1'b1)); // R4

endmodule

// File: rtl/frt_chain.sv
module frt_chain #(
  parameter int PRE_W   = 8,
  parameter int DATA_W  = 8,
  parameter int FRAME_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] word,
  input  logic              load_en,
  input  logic              shift_en,
  input  logic              holding,
  output logic              head_bit
);

  logic [FRAME_W-1:0] chain;

  // bit 0 goes out first: preamble ones, a zero start bit, then the data from its LSB
  function automatic logic [FRAME_W-1:0] build_frame(input logic [DATA_W-1:0] w);
    logic [FRAME_W-1:0] f;
    for (int i = 0; i < FRAME_W; i++) begin
      if (i < PRE_W)       f[i] = 1'b1;
      else if (i == PRE_W) f[i] = 1'b0;
      else                 f[i] = w[i-PRE_W-1];
    end
    return f;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)        chain <= '1;
    else if (load_en)  chain <= build_frame(word);
    else if (shift_en) chain <= {1'b1, chain[FRAME_W-1:1]};
  end

  assign head_bit = chain[0];

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && !load_en) |=> $stable(chain)); // R2
  AST_NO_LOAD_AND_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_en && shift_en)); // R6

endmodule

// File: rtl/frame_release_tx.sv
module frame_release_tx #(
  parameter int PREAMBLE_W = 8,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              load_stb,
  input  logic              go_stb,
  input  logic              pace_en,
  output logic              tx_line,
  output logic              tx_busy
);
  import frt_pkg::*;

  localparam int FRAME_W = frame_len(PREAMBLE_W, DATA_W);
  localparam int IDX_W   = index_width(PREAMBLE_W, DATA_W);

  frt_state_e       state;
  logic             load_take;
  logic             go_take;
  logic             bit_tick;
  logic             frame_done;
  logic             at_last_bit;
  logic [IDX_W-1:0] bit_idx;
  logic             head_bit;

  frt_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_stb    (load_stb),
    .go_stb      (go_stb),
    .pace_en     (pace_en),
    .at_last_bit (at_last_bit),
    .state       (state),
    .load_take   (load_take),
    .go_take     (go_take),
    .bit_tick    (bit_tick),
    .frame_done  (frame_done)
  );

  frt_bitcount #(.FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (go_take),
    .advance     (bit_tick),
    .bit_idx     (bit_idx),
    .at_last_bit (at_last_bit)
  );

  frt_chain #(.PRE_W(PREAMBLE_W), .DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .word     (tx_word),
    .load_en  (load_take),
    .shift_en (bit_tick),
    .holding  (state == ST_ARMED),
    .head_bit (head_bit)
  );

  assign tx_busy = (state == ST_STREAM);
  assign tx_line = tx_busy ? head_bit : 1'b1;

  AST_PREAMBLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && (int'(bit_idx) < PREAMBLE_W)) |-> tx_line); // R3
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && (int'(bit_idx) == PREAMBLE_W)) |-> !tx_line); // R3
  AST_BUSY_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> $past(frame_done)); // R7
  AST_BUSY_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
    go_take |=> (tx_busy && tx_line && (bit_idx == '0))); // R4

endmodule

// File: tb/test_frame_release_tx.sv
`timescale 1ns/1ps
module test_frame_release_tx;

  localparam int PRE = 8;
  localparam int DW  = 8;
  localparam int FL  = PRE + 1 + DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] tx_word = '0;
  logic          load_stb = 1'b0;
  logic          go_stb = 1'b0;
  logic          pace_en = 1'b0;
  logic          tx_line;
  logic          tx_busy;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  frame_release_tx #(.PREAMBLE_W(PRE), .DATA_W(DW)) i_frame_release_tx (
    .clk(clk), .rst_n(rst_n), .tx_word(tx_word), .load_stb(load_stb),
    .go_stb(go_stb), .pace_en(pace_en), .tx_line(tx_line), .tx_busy(tx_busy)
  );

  function automatic logic exp_bit(input logic [DW-1:0] d, input int k);
    if (k < PRE) return 1'b1;
    if (k == PRE) return 1'b0;
    return d[k-PRE-1];
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // called at a falling edge; drives strobes for one rising edge
  task automatic pulse(input logic l, input logic g, input logic p, input logic [DW-1:0] d);
    load_stb = l; go_stb = g; pace_en = p; tx_word = d;
    @(negedge clk);
    load_stb = 1'b0; go_stb = 1'b0; pace_en = 1'b0;
  endtask

  task automatic idle(input string req);
    chk(req, "busy", int'(tx_busy), 0);
    chk(req, "line", int'(tx_line), 1);
  endtask

  // starts at a falling edge with bit 0 on the line
  task automatic stream(input string req, input logic [DW-1:0] d, input int gap, input bit inject);
    for (int k = 0; k < FL; k++) begin
      for (int g = 0; g < gap; g++) begin
        chk(req, "line held", int'(tx_line), int'(exp_bit(d, k)));
        @(negedge clk);
      end
      chk(req, "line bit", int'(tx_line), int'(exp_bit(d, k)));
      chk(req, "busy", int'(tx_busy), 1);
      if (inject && k == 5) pulse(1'b1, 1'b0, 1'b1, ~d);
      else                  pulse(1'b0, 1'b0, 1'b1, '0);
    end
    idle("R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle("R9");

    // R5: release with nothing held after reset
    pulse(1'b0, 1'b1, 1'b0, '0);
    idle("R5");

    // full sweep of data words, with varying pacing gaps
    for (int d = 0; d < 256; d++) begin
      pulse(1'b1, 1'b0, 1'b0, DW'(d));
      idle("R2");
      pulse(1'b0, 1'b0, 1'b1, '0);          // pacing while armed
      idle("R2");
      pulse(1'b0, 1'b1, d[0], '0);          // R4: pace in the go cycle on odd words
      chk("R4", "busy after go", int'(tx_busy), 1);
      stream("R3", DW'(d), d % 3, 1'b0);
      pulse(1'b0, 1'b1, 1'b0, '0);          // frame consumed
      idle("R5");
    end

    // R1: last load before release wins
    pulse(1'b1, 1'b0, 1'b0, 8'h3C);
    pulse(1'b1, 1'b0, 1'b0, 8'hA5);
    pulse(1'b0, 1'b1, 1'b0, '0);
    stream("R1", 8'hA5, 0, 1'b0);

    // R6: load during streaming ignored
    pulse(1'b1, 1'b0, 1'b0, 8'h0F);
    pulse(1'b0, 1'b1, 1'b0, '0);
    stream("R6", 8'h0F, 1, 1'b1);
    pulse(1'b0, 1'b1, 1'b0, '0);
    idle("R6");

    // R8: armed, load and go together -> go wins
    pulse(1'b1, 1'b0, 1'b0, 8'h81);
    pulse(1'b1, 1'b1, 1'b0, 8'h7E);
    chk("R8", "busy armed", int'(tx_busy), 1);
    stream("R8", 8'h81, 0, 1'b0);
    pulse(1'b0, 1'b1, 1'b0, '0);
    idle("R8");

    // R8: empty, load and go together -> load wins
    pulse(1'b1, 1'b1, 1'b0, 8'h55);
    idle("R8");
    pulse(1'b0, 1'b1, 1'b0, '0);
    chk("R8", "busy after later go", int'(tx_busy), 1);
    stream("R8", 8'h55, 2, 1'b0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule